// File: doc/BRIEF.md
# Multi-Bank Activation Timing Tracker

This block watches the command stream sent to a four-bank DRAM and judges every command against the row timing rules before it reaches the memory. It keeps, for each bank, whether a row is open, which row that is, and how many clock cycles have passed since the bank was last activated. A single shared counter also measures the time since the most recent activation to any bank.

Each command arrives on a valid strobe with a two-bit operation code, a bank address and a row address. One cycle later the block reports a verdict: accepted or refused. Only accepted commands change bank state, so a controller can use the verdict to retry or reorder. Per-bank status (open flag, last activated row and an overdue flag for rows held open too long) is visible on the ports at all times. All timing limits are parameters counted in clock cycles.

Top module: `act_timing_tracker`

## Requirements
- R1: A READ (op 1) or WRITE (op 2) is refused when the addressed bank has no open row.
- R2: A READ or WRITE is refused unless at least TRCD cycles separate it from the ACTIVE (op 0) of that bank; a gap of exactly TRCD cycles is accepted.
- R3: An ACTIVE to a bank whose row is open is refused; an accepted PRECHARGE (op 3) closes the bank so that a later ACTIVE may open it.
- R4: An ACTIVE is refused when fewer than TRC cycles separate it from the previous accepted ACTIVE to the same bank.
- R5: An ACTIVE is refused when fewer than TRRD cycles separate it from the previous accepted ACTIVE to any bank.
- R6: A bank's overdue flag rises when its row has stayed open for more than TRAS_MAX cycles (not at exactly TRAS_MAX), and drops when the bank is precharged.
- R7: A refused command leaves every bank's open flag, stored row and counters unchanged.
- R8: A PRECHARGE to a bank that is already closed is accepted and changes nothing.
- R9: The verdict (res_vld, res_ok) appears the cycle after the command is presented; no command gives no verdict. Bank i's open flag is bank_open bit i and its row is bank_row bits 11*i+10 down to 11*i; the row is kept after a precharge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_vld | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 ACTIVE, 1 READ, 2 WRITE, 3 PRECHARGE |
| cmd_bank | input | 2 | Target bank |
| cmd_row | input | 11 | Row to open (ACTIVE only) |
| res_vld | output | 1 | Verdict valid for the previous cycle's command |
| res_ok | output | 1 | 1 accepted, 0 refused |
| bank_open | output | 4 | Per-bank open-row flag |
| bank_row | output | 44 | Per-bank last activated row, 11 bits each |
| bank_overdue | output | 4 | Per-bank row-open time exceeded |

## Verification
The verdict of a command presented in cycle t is due after the edge that captures it, and the bench reads it at the falling edge that follows; the open and row status for that command are read at the same falling edge because they are updated on the same capturing edge. A driver task computes each expected verdict and the resulting bank state from cycle stamps it keeps itself and queues them; a monitor pops one entry for every valid verdict, so a missing or extra verdict shows up as a queue mismatch. The overdue flag is checked at the falling edges where the open count equals TRAS_MAX and TRAS_MAX plus one, counted from the activating edge.

// File: rtl/acttrk_pkg.sv
package acttrk_pkg;
   typedef enum logic [1:0] {
      OP_ACT = 2'd0,
      OP_RD  = 2'd1,
      OP_WR  = 2'd2,
      OP_PRE = 2'd3
   } op_e;
endpackage

// File: rtl/acttrk_bank_slot.sv
module acttrk_bank_slot #(
   parameter int ROW_W    = 11,
   parameter int TRCD     = 3,
   parameter int TRC      = 10,
   parameter int TRAS_MAX = 40
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             act_go,
   input  logic             pre_go,
   input  logic [ROW_W-1:0] act_row,
   output logic             open_o,
   output logic [ROW_W-1:0] row_o,
   output logic             rcd_ok,
   output logic             rc_ok,
   output logic             overdue
);
   localparam int SAT = (TRC > TRAS_MAX + 1) ? TRC : TRAS_MAX + 1;
   localparam int CW  = $clog2(SAT + 1);
   localparam logic [CW-1:0] SAT_L  = CW'(SAT);
   localparam logic [CW-1:0] RCD_L  = CW'(TRCD);
   localparam logic [CW-1:0] RC_L   = CW'(TRC);
   localparam logic [CW-1:0] RAS_L  = CW'(TRAS_MAX);

   logic [CW-1:0] age_q;

   // age_q equals the gap, in cycles, to the activating edge
   always_ff @(posedge clk) begin
      if (!rst_n)              age_q <= SAT_L;
      else if (act_go)         age_q <= CW'(1);
      else if (age_q != SAT_L) age_q <= age_q + CW'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_o <= 1'b0;
         row_o  <= '0;
      end else if (act_go) begin
         open_o <= 1'b1;
         row_o  <= act_row;
      end else if (pre_go) begin
         open_o <= 1'b0;
      end
   end

   assign rcd_ok  = (age_q >= RCD_L);
   assign rc_ok   = (age_q >= RC_L);
   assign overdue = open_o && (age_q > RAS_L);

   AST_RCD_AFTER_ACT: assert property (@(posedge clk) disable iff (!rst_n)
      act_go |=> !rcd_ok); // R2
   AST_FRESH_NOT_OVERDUE: assert property (@(posedge clk) disable iff (!rst_n)
      act_go |=> (open_o && !overdue)); // R6
   AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (open_o && !pre_go) |=> (open_o && $stable(row_o))); // R7
endmodule

// File: rtl/acttrk_act_spacing.sv
module acttrk_act_spacing #(
   parameter int TRRD = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic any_act,
   output logic rrd_ok
);
   generate
      if (TRRD <= 1) begin : g_free
         logic unused_in;
         assign unused_in = clk ^ rst_n ^ any_act;
         assign rrd_ok = 1'b1;
      end else begin : g_count
         localparam int CW = $clog2(TRRD + 1);
         localparam logic [CW-1:0] SAT_L = CW'(TRRD);
         logic [CW-1:0] gap_q;
         always_ff @(posedge clk) begin
            if (!rst_n)              gap_q <= SAT_L;
            else if (any_act)        gap_q <= CW'(1);
            else if (gap_q != SAT_L) gap_q <= gap_q + CW'(1);
         end
         assign rrd_ok = (gap_q == SAT_L);

         AST_RRD_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
            any_act |=> !rrd_ok); // R5
      end
   endgenerate
endmodule

// File: rtl/act_timing_tracker.sv
module act_timing_tracker #(
   parameter int NUM_BANKS = 4,
   parameter int ROW_W     = 11,
   parameter int TRCD      = 3,
   parameter int TRC       = 10,
   parameter int TRRD      = 2,
   parameter int TRAS_MAX  = 40
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cmd_vld,
   input  logic [1:0]                 cmd_op,
   input  logic [$clog2(NUM_BANKS)-1:0] cmd_bank,
   input  logic [ROW_W-1:0]           cmd_row,
   output logic                       res_vld,
   output logic                       res_ok,
   output logic [NUM_BANKS-1:0]       bank_open,
   output logic [NUM_BANKS*ROW_W-1:0] bank_row,
   output logic [NUM_BANKS-1:0]       bank_overdue
);
   import acttrk_pkg::*;

   localparam int BA_W = $clog2(NUM_BANKS);

   generate
      if (NUM_BANKS < 2 || (1 << BA_W) != NUM_BANKS) begin : g_chk_nb
         $error("NUM_BANKS must be a power of two, at least 2");
      end
      if (TRCD < 2) begin : g_chk_rcd
         $error("TRCD must be at least 2");
      end
      if (TRC < TRRD || TRC < TRCD) begin : g_chk_rc
         $error("TRC must cover TRRD and TRCD");
      end
      if (TRAS_MAX < TRC) begin : g_chk_ras
         $error("TRAS_MAX must be at least TRC");
      end
   endgenerate

   op_e                 op;
   logic [NUM_BANKS-1:0] rcd_ok, rc_ok, act_go, pre_go;
   logic                rrd_ok, grant;

   assign op = op_e'(cmd_op);

   always_comb begin
      unique case (op)
         OP_ACT:       grant = !bank_open[cmd_bank] && rc_ok[cmd_bank] && rrd_ok;
         OP_RD, OP_WR: grant = bank_open[cmd_bank] && rcd_ok[cmd_bank];
         default:      grant = 1'b1;
      endcase
   end

   generate
      for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
         logic hit;
         assign hit       = cmd_vld && grant && (cmd_bank == BA_W'(i));
         assign act_go[i] = hit && (op == OP_ACT);
         assign pre_go[i] = hit && (op == OP_PRE);

         acttrk_bank_slot #(
            .ROW_W(ROW_W), .TRCD(TRCD), .TRC(TRC), .TRAS_MAX(TRAS_MAX)
         ) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .act_go  (act_go[i]),
            .pre_go  (pre_go[i]),
            .act_row (cmd_row),
            .open_o  (bank_open[i]),
            .row_o   (bank_row[i*ROW_W +: ROW_W]),
            .rcd_ok  (rcd_ok[i]),
            .rc_ok   (rc_ok[i]),
            .overdue (bank_overdue[i])
         );
      end
   endgenerate

   acttrk_act_spacing #(.TRRD(TRRD)) u_spacing (
      .clk     (clk),
      .rst_n   (rst_n),
      .any_act (|act_go),
      .rrd_ok  (rrd_ok)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_vld <= 1'b0;
         res_ok  <= 1'b0;
      end else begin
         res_vld <= cmd_vld;
         res_ok  <= cmd_vld && grant;
      end
   end

   AST_ACCESS_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_vld && (cmd_op == 2'd1 || cmd_op == 2'd2) && !bank_open[cmd_bank])
      |=> (res_vld && !res_ok)); // R1
   AST_ACT_OPEN_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_vld && cmd_op == 2'd0 && bank_open[cmd_bank]) |=> !res_ok); // R3
   AST_PRE_ALWAYS_OK: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_vld && cmd_op == 2'd3) |=> (res_vld && res_ok)); // R8
   AST_NO_CMD_NO_RES: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_vld |=> !res_vld); // R9
   AST_ONE_ACT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(act_go)); // R5
endmodule

// File: tb/act_timing_tracker_bench.sv
`timescale 1ns/1ps
module act_timing_tracker_bench;
   localparam int NB = 4, RW = 11, TRCD = 3, TRC = 10, TRRD = 2, TRAS_MAX = 40;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cmd_vld = 1'b0;
   logic [1:0] cmd_op = '0, cmd_bank = '0;
   logic [RW-1:0] cmd_row = '0;
   logic res_vld, res_ok;
   logic [NB-1:0] bank_open, bank_overdue;
   logic [NB*RW-1:0] bank_row;

   act_timing_tracker #(.NUM_BANKS(NB), .ROW_W(RW), .TRCD(TRCD), .TRC(TRC),
      .TRRD(TRRD), .TRAS_MAX(TRAS_MAX)) u_act_timing_tracker (
      .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_op(cmd_op),
      .cmd_bank(cmd_bank), .cmd_row(cmd_row), .res_vld(res_vld),
      .res_ok(res_ok), .bank_open(bank_open), .bank_row(bank_row),
      .bank_overdue(bank_overdue));

   always #10 clk = ~clk;

   typedef struct {
      logic ok;
      logic [NB-1:0] open;
      logic [RW-1:0] row;
      int bank;
      string tag;
   } exp_t;

   exp_t q[$];
   int compared = 0, mismatched = 0;
   int cyc = 0;
   logic [NB-1:0] m_open = '0;
   logic [RW-1:0] m_row[NB];
   int m_last[NB];
   int m_any = -1000;
   bit done = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // driver: models the rules by cycle stamps, queues the expectation
   task automatic issue(input logic [1:0] op, input int b, input logic [RW-1:0] row, input string tag);
      int c;
      logic ok;
      exp_t e;
      @(negedge clk);
      c = cyc + 1;
      case (op)
         2'd0: ok = !m_open[b] && (c - m_last[b] >= TRC) && (c - m_any >= TRRD);
         2'd1, 2'd2: ok = m_open[b] && (c - m_last[b] >= TRCD);
         default: ok = 1'b1;
      endcase
      if (ok && op == 2'd0) begin
         m_open[b] = 1'b1; m_row[b] = row; m_last[b] = c; m_any = c;
      end else if (ok && op == 2'd3) begin
         m_open[b] = 1'b0;
      end
      e.ok = ok; e.open = m_open; e.row = m_row[b]; e.bank = b; e.tag = tag;
      q.push_back(e);
      cmd_vld = 1'b1; cmd_op = op; cmd_bank = b[1:0]; cmd_row = row;
   endtask

   task automatic idle();
      @(negedge clk);
      cmd_vld = 1'b0;
   endtask

   // monitor
   always @(negedge clk) begin
      if (rst_n && res_vld) begin
         if (q.size() == 0) begin
            check("R9 unexpected verdict", 1, 0);
         end else begin
            exp_t e;
            e = q.pop_front();
            check({e.tag, " verdict"}, {63'd0, res_ok}, {63'd0, e.ok});
            check({e.tag, " open flags R7"}, {60'd0, bank_open}, {60'd0, e.open});
            check({e.tag, " row R7"}, {53'd0, bank_row[e.bank*RW +: RW]}, {53'd0, e.row});
         end
      end
   end

   initial begin
      #(20 * 20000);
      if (!done) begin
         mismatched++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NB; i++) begin m_row[i] = '0; m_last[i] = -1000; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9 reset res_vld", {63'd0, res_vld}, 0);
      check("R9 reset open", {60'd0, bank_open}, 0);
      check("R6 reset overdue", {60'd0, bank_overdue}, 0);

      issue(2'd1, 0, 11'h000, "R1");       // read closed bank
      issue(2'd0, 0, 11'h123, "R3");       // open bank 0
      issue(2'd1, 0, 11'h000, "R2");       // gap 1 < TRCD
      issue(2'd0, 1, 11'h456, "R5");       // gap 2 == TRRD
      issue(2'd2, 0, 11'h000, "R2");       // gap 3 == TRCD
      issue(2'd0, 2, 11'h0AA, "R5");       // gap 2
      issue(2'd0, 3, 11'h055, "R5");       // gap 1 < TRRD
      issue(2'd0, 3, 11'h066, "R5");       // gap 2
      issue(2'd0, 0, 11'h3FF, "R3");       // bank 0 open, row must stay
      issue(2'd3, 0, 11'h000, "R3");       // close bank 0
      issue(2'd0, 0, 11'h7FF, "R4");       // gap 9 < TRC
      issue(2'd0, 0, 11'h7FF, "R4");       // gap 10 == TRC
      issue(2'd3, 1, 11'h000, "R8");
      issue(2'd3, 1, 11'h000, "R8");       // closed bank no-op
      issue(2'd2, 1, 11'h000, "R1");
      idle();

      for (int n = 0; n < 500; n++) begin
         if ($urandom_range(0, 4) == 0) idle();
         else issue(2'($urandom_range(0, 3)), int'($urandom_range(0, NB - 1)),
                    RW'($urandom_range(0, 2047)), "R7");
      end
      for (int i = 0; i < NB; i++) issue(2'd3, i, 11'h000, "R8");
      repeat (20) idle();

      issue(2'd0, 2, 11'h2C3, "R6");
      idle();                               // open count 1 here
      repeat (TRAS_MAX - 1) idle();         // open count TRAS_MAX
      check("R6 not yet overdue", {63'd0, bank_overdue[2]}, 0);
      idle();
      check("R6 overdue", {63'd0, bank_overdue[2]}, 1);
      check("R6 other banks", {61'd0, bank_overdue[3], bank_overdue[1:0]}, 0);
      issue(2'd3, 2, 11'h000, "R6");
      idle();
      check("R6 cleared by precharge", {63'd0, bank_overdue[2]}, 0);
      repeat (3) idle();
      check("R9 queue drained", q.size(), 0);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule